// File: doc/BRIEF.md
# Serial Majority-Logic Decoder with Early Exit

This block corrects a 15-bit word of the cyclic (15,7) Euclidean-geometry LDPC code. Its generator polynomial is g(x) = 1 + x^4 + x^6 + x^7 + x^8. The decoder loads the word into a circular register. It then works on one bit per clock. In each cycle four parity sums are formed. Each sum has weight 4, and the four sums share only the bit at the top position. When three or more of the sums are 1, that bit is inverted. The register then turns by one place, and the same logic serves the next bit.

The first three cycles of a decode also act as an error detector. If every sum is zero in all three of those cycles, the word is declared clean. The decoder stops at that point and returns the word in its loaded alignment. Any other word goes through all fifteen turns, which leaves the register back in its original alignment. A one-cycle completion pulse then presents the corrected 15-bit codeword together with a flag that tells whether the detection window saw a nonzero sum.

Top module: `mld_decoder_top`

## Requirements
- R1: While reset is applied, and after it is released until the first decode completes, `done_o`, `err_o` and `data_o` are all zero.
- R2: A high `start_i` while the decoder is idle captures `code_i`, and exactly one completion pulse follows. Bit i of `code_i` is the coefficient of x^i of the received polynomial. A sent word is a multiple of g(x) plus an error pattern.
- R3: When none of the four sums is 1 in any of the first three decode cycles, `done_o` rises on the 3rd rising edge after the edge that samples `start_i`. In that case `data_o` equals the captured word and `err_o` is 0.
- R4: Any word with exactly one flipped bit is returned as the original codeword. `done_o` then rises on the 15th rising edge after the edge that samples `start_i`.
- R5: Any word with exactly two flipped bits is returned as the original codeword, with the same 15-edge latency as R4.
- R6: A `start_i` pulse that arrives while a decode is running is ignored. The result, the latency and the number of completions of the running decode are unchanged.
- R7: `done_o` is high for one cycle per decode. `data_o` and `err_o` change only in a cycle where `done_o` is high, and they hold their values until the next completion.
- R8: The four sums are taken over bit positions {14,0,2,6}, {14,13,1,5}, {14,11,12,3} and {14,7,8,10}. Bit 14 is inverted when at least 3 of the 4 sums are 1. Each turn moves bit i to bit i+1 and moves bit 14 to bit 0.
- R9: `err_o` is 1 at completion if and only if some sum was 1 during the three-cycle detection window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin decoding `code_i`; ignored while busy |
| code_i | input | 15 | Received word |
| data_o | output | 15 | Corrected codeword, valid from the `done_o` cycle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Detection window saw a nonzero sum |

## Verification
Faults in the turn counter or in the exit decision show up at the ports as a completion pulse on the wrong edge. That edge is either the 3rd or the 15th after start, so a wrong one appears within sixteen cycles of the faulty decode. A wrong sum tap, a wrong vote threshold or a wrong rotation direction corrupts the returned word for some single-bit or two-bit error pattern. Every such pattern is sent, and the returned word is compared when its own decode completes. A busy flag that does not hold shows up as an extra completion or as the result of the ignored word.

// File: rtl/mld_pkg.sv
package mld_pkg;

  // Points of one line of the geometry, relative to its first point.
  localparam int unsigned LINE_WEIGHT = 4;
  localparam int unsigned LINE_OFS [LINE_WEIGHT] = '{0, 1, 3, 7};

  // Bit index of tap m of check sum j. Every sum passes through bit n-1.
  function automatic int unsigned tap_index(int unsigned j, int unsigned m, int unsigned n);
    return (n - 1 - LINE_OFS[j] + LINE_OFS[m]) % n;
  endfunction

endpackage

// File: rtl/mld_checksums.sv
module mld_checksums
  import mld_pkg::*;
#(
  parameter int unsigned N = 15
) (
  input  logic [N-1:0]           word_i,
  output logic [LINE_WEIGHT-1:0] sum_o
);

  for (genvar j = 0; j < LINE_WEIGHT; j++) begin : g_sum
    logic [LINE_WEIGHT-1:0] taps;
    for (genvar m = 0; m < LINE_WEIGHT; m++) begin : g_tap
      assign taps[m] = word_i[tap_index(j, m, N)];
    end
    assign sum_o[j] = ^taps;
  end

endmodule

// File: rtl/mld_vote.sv
module mld_vote #(
  parameter int unsigned J      = 4,
  parameter int unsigned THRESH = 3
) (
  input  logic [J-1:0] sum_i,
  output logic         flip_o,
  output logic         any_o
);

  localparam int unsigned CW = $clog2(J + 1);
  localparam logic [CW-1:0] THR = CW'(THRESH);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < J; i++) begin
      ones = ones + {{(CW-1){1'b0}}, sum_i[i]};
    end
  end

  assign flip_o = (ones >= THR);
  assign any_o  = |sum_i;

endmodule

// File: rtl/mld_ctrl.sv
module mld_ctrl #(
  parameter int unsigned N   = 15,
  parameter int unsigned WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic any_i,
  output logic busy_o,
  output logic load_o,
  output logic early_o,
  output logic full_o,
  output logic err_o
);

  localparam int unsigned CW = $clog2(N);
  localparam logic [CW-1:0] LAST  = CW'(N - 1);
  localparam logic [CW-1:0] WLAST = CW'(WIN - 1);

  logic          busy_q, busy_d;
  logic          seen_q, seen_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_win, hit;

  always_comb begin
    load_o  = start_i & ~busy_q;
    in_win  = (cnt_q <= WLAST);
    hit     = busy_q & in_win & any_i;
    early_o = busy_q & (cnt_q == WLAST) & ~(seen_q | any_i);
    full_o  = busy_q & (cnt_q == LAST);
    err_o   = seen_q | hit;

    busy_d = busy_q;
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (hit) seen_d = 1'b1;
      if (early_o || full_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !early_o && !full_o) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));

endmodule

// File: rtl/mld_decoder_top.sv
module mld_decoder_top
  import mld_pkg::*;
#(
  parameter int unsigned N      = 15,
  parameter int unsigned WIN    = 3,
  parameter int unsigned THRESH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N-1:0] code_i,
  output logic [N-1:0] data_o,
  output logic         done_o,
  output logic         err_o
);

  // Reset asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N-1:0]           word_q, word_d;
  logic [N-1:0]           data_q, data_d;
  logic                   done_q, done_d;
  logic                   err_q, err_d;
  logic [LINE_WEIGHT-1:0] sums;
  logic                   flip, any_sum;
  logic                   busy, load, early, full, err_res;
  logic [N-1:0]           rot_word, early_word;

  mld_checksums #(.N(N)) u_sums (
    .word_i (word_q),
    .sum_o  (sums)
  );

  mld_vote #(.J(LINE_WEIGHT), .THRESH(THRESH)) u_vote (
    .sum_i  (sums),
    .flip_o (flip),
    .any_o  (any_sum)
  );

  mld_ctrl #(.N(N), .WIN(WIN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .any_i   (any_sum),
    .busy_o  (busy),
    .load_o  (load),
    .early_o (early),
    .full_o  (full),
    .err_o   (err_res)
  );

  // Undo the WIN-1 turns done before an early exit.
  for (genvar i = 0; i < N; i++) begin : g_unrot
    assign early_word[i] = word_q[(i + WIN - 1) % N];
  end

  always_comb begin
    rot_word = {word_q[N-2:0], word_q[N-1] ^ flip};

    word_d = word_q;
    if (load)      word_d = code_i;
    else if (busy) word_d = rot_word;

    done_d = early | full;
    data_d = data_q;
    err_d  = err_q;
    if (early) begin
      data_d = early_word;
      err_d  = err_res;
    end else if (full) begin
      data_d = rot_word;
      err_d  = err_res;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      word_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      data_q <= data_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$stable(data_o) || !$stable(err_o)) |-> done_o);

endmodule

// File: tb/sim_mld_decoder_top.sv
module sim_mld_decoder_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [14:0] code;
  logic [14:0] data;
  logic        done;
  logic        err;

  always #(CLK_PERIOD/2) clk = ~clk;

  mld_decoder_top u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .code_i  (code),
    .data_o  (data),
    .done_o  (done),
    .err_o   (err)
  );

  typedef struct {
    logic [14:0] word;
    logic        err;
    int          lat;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   n_sent = 0;
  int   n_done = 0;
  bit   running = 0;
  int   timer = 0;
  bit   was_done = 0;
  bit   finished = 0;
  logic [14:0] last_data;
  logic        last_err;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Codeword = message polynomial times 1+x^4+x^6+x^7+x^8
  function automatic logic [14:0] enc(input logic [6:0] m);
    logic [14:0] c = '0;
    for (int i = 0; i < 7; i++)
      if (m[i]) c = c ^ (15'h01D1 << i);
    return c;
  endfunction

  // Driver: waits for idle, pulses start, pushes the expected result.
  task automatic send(input logic [14:0] w, input logic [14:0] expw,
                      input logic experr, input string tag);
    exp_t e;
    @(posedge clk);
    while (running) @(posedge clk);
    #QTR;
    start = 1'b1;
    code  = w;
    e.word = expw;
    e.err  = experr;
    e.lat  = experr ? 16 : 4;
    e.tag  = tag;
    q.push_back(e);
    n_sent++;
    @(posedge clk);
    #QTR;
    start = 1'b0;
  endtask

  // Start pulse during a running decode: no expected item.
  task automatic poke(input logic [14:0] w);
    @(posedge clk);
    #QTR;
    start = 1'b1;
    code  = w;
    @(posedge clk);
    #QTR;
    start = 1'b0;
  endtask

  // Monitor: samples on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      timer++;
      if (was_done) begin
        check(done == 1'b0, "R7", "done width", 32'(done), 32'd0);
        check(data == last_data, "R7", "data hold", 32'(data), 32'(last_data));
        check(err == last_err, "R7", "err hold", 32'(err), 32'(last_err));
      end
      was_done = 0;
      if (done) begin
        exp_t e;
        n_done++;
        running = 0;
        was_done = 1;
        last_data = data;
        last_err = err;
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
        end else begin
          e = q.pop_front();
          check(data == e.word, e.tag, "data (R8)", 32'(data), 32'(e.word));
          check(err == e.err, "R9", "err flag", 32'(err), 32'(e.err));
          check(timer == e.lat, e.err ? "R4" : "R3", "latency", 32'(timer), 32'(e.lat));
        end
      end
      if (start && !running) begin
        running = 1;
        timer = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [14:0] c;
    logic [14:0] c2;
    rst_n = 1'b0;
    start = 1'b0;
    code  = '0;
    repeat (3) @(posedge clk);
    #QTR;
    check(done == 1'b0, "R1", "done in reset", 32'(done), 32'd0);
    check(err == 1'b0, "R1", "err in reset", 32'(err), 32'd0);
    check(data == 15'd0, "R1", "data in reset", 32'(data), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #QTR;
    check(done == 1'b0, "R1", "done after release", 32'(done), 32'd0);
    check(data == 15'd0, "R1", "data after release", 32'(data), 32'd0);

    // R3: clean words exit early
    foreach (q[i]) ;
    for (int k = 0; k < 6; k++) begin
      logic [6:0] m;
      case (k)
        0: m = 7'h00;
        1: m = 7'h7F;
        2: m = 7'h55;
        3: m = 7'h2A;
        4: m = 7'h01;
        default: m = 7'h40;
      endcase
      send(enc(m), enc(m), 1'b0, "R3");
    end

    // R4: every single-bit error
    c = enc(7'h35);
    for (int b = 0; b < 15; b++)
      send(c ^ (15'd1 << b), c, 1'b1, "R4");

    // R5: every two-bit error
    c = enc(7'h5A);
    for (int a = 0; a < 15; a++)
      for (int b = a + 1; b < 15; b++)
        send(c ^ (15'd1 << a) ^ (15'd1 << b), c, 1'b1, "R5");

    // R6: start during a running decode is ignored
    c  = enc(7'h13);
    c2 = enc(7'h6C);
    send(c ^ 15'h0201, c, 1'b1, "R6");
    repeat (4) @(posedge clk);
    poke(c2);
    send(c2, c2, 1'b0, "R6");

    repeat (40) @(posedge clk);
    #QTR;
    check(n_done == n_sent, "R2", "completion count", 32'(n_done), 32'(n_sent));
    check(q.size() == 0, "R6", "pending items", 32'(q.size()), 32'd0);
    summary();
  end

endmodule